// File: doc/BRIEF.md
# Command DMA Fetch Request Controller

This block decides when a command fetch engine may ask memory for another burst of command data. An upstream arbitration controller raises a fetch request while a command stream is active. The controller then checks how much room is left in the command FIFO. It raises a memory request only when at least one full burst of returning data fits. It keeps that request asserted until memory acknowledges it.

When the FIFO lacks room, the controller parks in a space-wait state and makes no request. A stop request returns the block to idle. If the stop arrives while a request is outstanding, the block first completes the handshake with memory and then goes idle.

The current state is reported on a 2-bit status port for debug readback. A separate idle flag tells the arbitration logic when no DMA activity remains.

Top module: `dma_fetch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle: `state_code` = 2'b00, `dma_idle` = 1 and `mem_req` = 0.
- R2: In idle, a cycle with `fetch_req` = 1 and `stop_req` = 0 moves the block to the request state (code 2'b01) at the next edge. Any other input combination leaves it idle.
- R3: In the request state, when `stop_req` = 0, the block goes to acknowledge-wait (code 2'b11) if `free_cnt` >= BURST. Otherwise it goes to space-wait (code 2'b10). A request is never raised without that room.
- R4: Space-wait holds while `free_cnt` < BURST and `stop_req` = 0. It moves to acknowledge-wait on the first cycle in which `free_cnt` >= BURST.
- R5: `mem_req` is high exactly in acknowledge-wait. It stays high every cycle until a cycle with `mem_ack` = 1.
- R6: When an acknowledge is taken with no stop seen during the handshake, the block returns to the request state if `fetch_req` = 1, and to idle otherwise.
- R7: `stop_req` = 1 in idle, request or space-wait sends the block to idle at the next edge without raising `mem_req`.
- R8: `stop_req` seen in any cycle of acknowledge-wait keeps the request held until `mem_ack`. The block then goes to idle, even if the stop has been released and `fetch_req` is high.
- R9: `dma_idle` is high exactly when `state_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request from the arbitration controller |
| stop_req | input | 1 | Request to halt DMA fetching |
| free_cnt | input | FREE_W | Free FIFO entries |
| mem_ack | input | 1 | Memory acknowledge of the outstanding request |
| mem_req | output | 1 | Memory read request for one burst |
| dma_idle | output | 1 | High when no DMA activity remains |
| state_code | output | 2 | Encoded current state (00 idle, 01 request, 10 space-wait, 11 ack-wait) |

## Verification
The bench builds the block with BURST = 4 and FREE_W = 5. With these values the free count can sit exactly at BURST-1 and at BURST, which exercises both sides of the room decision. The count can also range up to 31 entries, so several bursts can be in flight before the FIFO fills. The FIFO model removes BURST entries on each acknowledge and drains at chosen rates. Acknowledge latencies of zero to several cycles drive the space-wait and held-request paths back to back.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    typedef enum logic [1:0] {
        DFC_IDLE  = 2'b00,
        DFC_REQ   = 2'b01,
        DFC_SPACE = 2'b10,
        DFC_ACK   = 2'b11
    } dfc_state_e;

    typedef struct packed {
        logic fetch;
        logic stop;
        logic room;
        logic ack;
        logic stop_held;
    } dfc_ctl_t;

    function automatic dfc_state_e dfc_after_ack(input logic more, input logic halt);
        return (more && !halt) ? DFC_REQ : DFC_IDLE;
    endfunction

    function automatic dfc_state_e dfc_room_pick(input logic room);
        return room ? DFC_ACK : DFC_SPACE;
    endfunction

endpackage

// File: rtl/dfc_space_check.sv
module dfc_space_check #(
    parameter int BURST  = 4,
    parameter int FREE_W = 6
) (
    input  logic [FREE_W-1:0] free_cnt,
    output logic              room
);
    localparam logic [FREE_W:0] NEED = (FREE_W+1)'(BURST);

    always_comb room = ({1'b0, free_cnt} >= NEED);
endmodule

// File: rtl/dfc_stop_latch.sv
module dfc_stop_latch (
    input  logic clk,
    input  logic rst,
    input  logic in_ack_wait,
    input  logic stop_req,
    input  logic mem_ack,
    output logic stop_held
);
    always_ff @(posedge clk) begin
        if (rst)
            stop_held <= 1'b0;
        else if (in_ack_wait && !mem_ack)
            stop_held <= stop_held | stop_req;
        else
            stop_held <= 1'b0;
    end
endmodule

// File: rtl/dfc_fsm.sv
module dfc_fsm
    import dfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dfc_ctl_t   ctl,
    output dfc_state_e state
);
    dfc_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            DFC_IDLE:  if (ctl.fetch && !ctl.stop) nxt = DFC_REQ;
            DFC_REQ:   nxt = ctl.stop ? DFC_IDLE : dfc_room_pick(ctl.room);
            DFC_SPACE: begin
                if (ctl.stop)      nxt = DFC_IDLE;
                else if (ctl.room) nxt = DFC_ACK;
            end
            DFC_ACK:   if (ctl.ack) nxt = dfc_after_ack(ctl.fetch, ctl.stop | ctl.stop_held);
            default:   nxt = DFC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= DFC_IDLE;
        else     state <= nxt;
    end

    assert_space_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == DFC_SPACE && !ctl.stop && !ctl.room) |=> (state == DFC_SPACE));

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state != DFC_ACK && ctl.stop) |=> (state == DFC_IDLE));

    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == DFC_IDLE && !ctl.fetch) |=> (state == DFC_IDLE));
endmodule

// File: rtl/dma_fetch_ctrl.sv
module dma_fetch_ctrl
    import dfc_pkg::*;
#(
    parameter int BURST  = 4,
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic              stop_req,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              dma_idle,
    output logic [1:0]        state_code
);
    dfc_state_e state;
    dfc_ctl_t   ctl;
    logic       room;
    logic       stop_held;

    dfc_space_check #(.BURST(BURST), .FREE_W(FREE_W)) u_space (
        .free_cnt (free_cnt),
        .room     (room)
    );

    dfc_stop_latch u_stop (
        .clk         (clk),
        .rst         (rst),
        .in_ack_wait (state == DFC_ACK),
        .stop_req    (stop_req),
        .mem_ack     (mem_ack),
        .stop_held   (stop_held)
    );

    always_comb begin
        ctl.fetch     = fetch_req;
        ctl.stop      = stop_req;
        ctl.room      = room;
        ctl.ack       = mem_ack;
        ctl.stop_held = stop_held;
    end

    dfc_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .state (state)
    );

    always_comb begin
        mem_req    = (state == DFC_ACK);
        dma_idle   = (state == DFC_IDLE);
        state_code = state;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state_code == 2'b00 && !mem_req && dma_idle));

    assert_req_room_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(room));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    assert_halt_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && stop_held) |=> dma_idle);
endmodule

// File: tb/dma_fetch_ctrl_bench.sv
`timescale 1ns/1ps
module dma_fetch_ctrl_bench;
    localparam int BURST  = 4;
    localparam int FREE_W = 5;
    localparam int FMAX   = 31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_req = 1'b0, stop_req = 1'b0, mem_ack = 1'b0;
    logic [FREE_W-1:0] free_cnt = '0;
    logic mem_req, dma_idle;
    logic [1:0] state_code;

    int n_tests = 0;
    int n_fail  = 0;
    int m_state = 0;
    bit m_pend  = 0;
    string m_tag = "R1";

    always #2 clk = ~clk;

    dma_fetch_ctrl #(.BURST(BURST), .FREE_W(FREE_W)) u_dma_fetch_ctrl (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .stop_req(stop_req),
        .free_cnt(free_cnt), .mem_ack(mem_ack), .mem_req(mem_req),
        .dma_idle(dma_idle), .state_code(state_code)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit f, input bit s, input int fr, input bit a);
        case (m_state)
            0: begin m_tag = "R2"; if (f && !s) m_state = 1; end
            1: if (s) begin m_tag = "R7"; m_state = 0; end
               else begin m_tag = "R3"; m_state = (fr >= BURST) ? 3 : 2; end
            2: if (s) begin m_tag = "R7"; m_state = 0; end
               else begin m_tag = "R4"; if (fr >= BURST) m_state = 3; end
            default: begin
                if (a) begin
                    if (s || m_pend) begin m_tag = "R8"; m_state = 0; end
                    else begin m_tag = "R6"; m_state = f ? 1 : 0; end
                    m_pend = 0;
                end else begin
                    if (s) m_pend = 1;
                    m_tag = m_pend ? "R8" : "R5";
                end
            end
        endcase
    endtask

    task automatic compare_all();
        check(m_tag, int'(state_code), m_state, "state_code");
        check("R5", int'(mem_req), (m_state == 3) ? 1 : 0, "mem_req");
        check("R9", int'(dma_idle), (m_state == 0) ? 1 : 0, "dma_idle");
    endtask

    task automatic step(input bit f, input bit s, input int fr, input bit a);
        @(negedge clk);
        fetch_req = f; stop_req = s; free_cnt = fr[FREE_W-1:0]; mem_ack = a;
        @(posedge clk);
        model_step(f, s, fr, a);
        #1;
        compare_all();
    endtask

    task automatic traffic(input int cycles, input int lat, input int drain_period, input int stop_at);
        int free = FMAX;
        int wc = 0;
        for (int i = 0; i < cycles; i++) begin
            bit a;
            bit s;
            @(negedge clk);
            a = mem_req && (wc >= lat);
            s = (i == stop_at);
            if (mem_req && !a) wc++; else wc = 0;
            if ((i % drain_period) == 0 && free < FMAX) free++;
            fetch_req = 1'b1; stop_req = s; free_cnt = free[FREE_W-1:0]; mem_ack = a;
            @(posedge clk);
            model_step(1'b1, s, free, a);
            if (a) free -= BURST;
            #1;
            compare_all();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(state_code), 0, "reset state_code");
        check("R1", int'(mem_req), 0, "reset mem_req");
        check("R1", int'(dma_idle), 1, "reset dma_idle");
        @(negedge clk); rst = 1'b0;

        step(0, 0, 20, 0);                          // R2 idle holds
        step(1, 1, 20, 0);                          // R2/R7 stop blocks start
        step(1, 0, BURST-1, 0);                     // R2 to request
        step(1, 0, BURST-1, 0);                     // R3 no room -> space-wait
        for (int i = 0; i < 4; i++) step(1, 0, BURST-1, 0);  // R4 hold
        step(1, 0, BURST, 0);                       // R4 room -> ack-wait
        for (int i = 0; i < 3; i++) step(1, 0, BURST, 0);    // R5 held
        step(1, 0, BURST, 1);                       // R6 ack with fetch -> request
        step(1, 0, 10, 0);                          // R3 room -> ack-wait
        step(0, 0, 10, 1);                          // R6 ack without fetch -> idle
        step(1, 0, 2, 0);                           // request
        step(1, 0, 2, 0);                           // space-wait
        step(1, 1, 2, 0);                           // R7 stop in space-wait
        step(1, 0, 2, 0);
        step(1, 1, 2, 0);                           // R7 stop in request
        step(1, 0, 20, 0);
        step(1, 0, 20, 0);                          // ack-wait
        step(1, 1, 20, 0);                          // R8 stop seen
        step(1, 0, 20, 0);                          // R8 held, stop released
        step(1, 0, 20, 0);
        step(1, 0, 20, 1);                          // R8 ack -> idle
        step(1, 0, 20, 0);
        step(1, 0, 20, 0);
        step(1, 1, 20, 1);                          // R8 stop with ack same cycle

        traffic(200, 0, 1, -1);
        traffic(300, 3, 2, 150);
        traffic(300, 1, 5, -1);
        traffic(200, 6, 1, 77);

        @(negedge clk); rst = 1'b1; fetch_req = 1'b1; stop_req = 1'b0;
        @(posedge clk); #1;
        m_state = 0; m_pend = 0;
        check("R1", int'(state_code), 0, "mid-run reset state_code");
        check("R1", int'(mem_req), 0, "mid-run reset mem_req");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule